// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block controls a successive-approximation converter. Software uses it through four word registers: a result register, a status register, a control register and a start-delay register. A single write to the control register picks an input channel, enables the interrupt and powers the converter. After a programmable number of clocks, the block runs the bit-serial approximation, one trial bit per clock. It does this through a DAC code output and a comparator input. When the last bit is decided, the result is latched and an interrupt flag is set. Writing zero to the control register clears the interrupt, powers the converter down and also aborts a conversion that is still running.

The comparator and DAC are outside the block. The block presents a trial code and a channel number, and samples `cmp_hi`. That input is high when the selected analog input is at or above the DAC level.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, the result reads 0, status reads 0, control reads 0, start-delay reads 8, `irq` is low and `dac_code` is 0.
- R2: Byte offsets are as follows. 0x0 holds the result in bits [RES-1:0]. 0x4 holds busy in bit 0. 0x8 is control: bit 6 interrupt status, bit 5 interrupt enable, bit 3 power, bits [2:0] channel. 0xC holds the 6-bit start delay in bits [5:0]. Other bits read 0.
- R3: A nonzero control write with bit 3 set while idle makes busy read 1 from the next cycle. The first trial code appears D+1 clocks after the write edge, where D is the start delay. Busy lasts D+1+RES clocks in total.
- R4: The approximation runs from MSB to LSB, one bit per clock. Each trial starts with the bit set, and the bit is kept only when `cmp_hi` is high. `dac_code` is 0 outside the conversion. The result equals the input value quantized to RES bits.
- R5: At completion, the result register is loaded and control bit 6 is set. `irq` equals control bit 6 AND control bit 5.
- R6: A control write of 0 clears control and `irq`, drops `adc_pwr`, and returns to idle at once, even mid-conversion. The result register is kept.
- R7: A nonzero control write while busy is ignored. The channel and the conversion in progress are unchanged.
- R8: A channel number at or above NCH converts channel 0. `adc_chan` never reaches NCH.
- R9: With a start delay of 0, the first trial code is presented on the clock after the control write.
- R10: A nonzero control write accepted while idle clears control bit 6. If bit 3 of that write is 0, no conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| adc_pwr | output | 1 | Converter power enable |
| adc_chan | output | 3 | Channel driven to the analog mux |
| dac_code | output | RES | Trial code for the DAC |
| cmp_hi | input | 1 | Comparator: input at or above the DAC level |

## Verification
The bench attacks the timing edges: a zero start delay, and the exact busy length for several delays. An off-by-one counter would stretch or shorten busy, or present the MSB trial a cycle late. Full-scale, zero, alternating and just-above-midscale inputs expose a trial bit that is never set or wrongly kept. An abort in the middle of the start delay must leave the old result and no interrupt. A broken abort path would instead finish the conversion and raise `irq`. A channel switch written while busy, and an out-of-range channel, would convert the wrong input if the write guard or the channel clamp were missing.

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int RES     = 10,
  parameter int NCH     = 6,
  parameter int DW      = 32,
  parameter int DLY_RST = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          adc_pwr,
  output logic [2:0]    adc_chan,
  output logic [RES-1:0] dac_code,
  input  logic          cmp_hi
);
  localparam int BW = (RES > 1) ? $clog2(RES) : 1;
  localparam logic [3:0] NCH4 = 4'(NCH);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CONV} st_t;

  st_t            st;
  logic [5:0]     cnt, dly;
  logic [BW-1:0]  bitp;
  logic [RES-1:0] sar, sar_nx, data_q;
  logic           ien, pwr, irq_st;
  logic [2:0]     chan;

  wire ctrl_we = reg_we && reg_addr == 4'h8;
  wire dly_we  = reg_we && reg_addr == 4'hC;
  wire wzero   = reg_wdata == '0;
  wire busy    = st != S_IDLE;
  wire conv    = st == S_CONV;

  always_comb begin
    sar_nx = sar;
    if (!cmp_hi) sar_nx[bitp] = 1'b0;
    if (bitp != '0) sar_nx[bitp - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; dly <= 6'(DLY_RST); bitp <= '0;
      sar <= '0; data_q <= '0; ien <= 1'b0; pwr <= 1'b0;
      irq_st <= 1'b0; chan <= '0;
    end else begin
      if (dly_we) dly <= reg_wdata[5:0];
      if (ctrl_we && wzero) begin
        st <= S_IDLE; ien <= 1'b0; pwr <= 1'b0; irq_st <= 1'b0; chan <= '0;
      end else begin
        if (ctrl_we && !busy) begin
          ien    <= reg_wdata[5];
          pwr    <= reg_wdata[3];
          chan   <= reg_wdata[2:0];
          irq_st <= 1'b0;
          if (reg_wdata[3]) begin
            st  <= S_WAIT;
            cnt <= dly;
          end
        end
        case (st)
          S_WAIT:
            if (cnt == '0) begin
              st   <= S_CONV;
              sar  <= {1'b1, {(RES-1){1'b0}}};
              bitp <= BW'(RES - 1);
            end else begin
              cnt <= cnt - 1'b1;
            end
          S_CONV: begin
            sar <= sar_nx;
            if (bitp != '0) begin
              bitp <= bitp - 1'b1;
            end else begin
              data_q <= sar_nx;
              irq_st <= 1'b1;
              st     <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign irq      = irq_st & ien;
  assign adc_pwr  = pwr;
  assign adc_chan = ({1'b0, chan} < NCH4) ? chan : 3'd0;
  assign dac_code = conv ? sar : '0;

  always_comb begin
    case (reg_addr)
      4'h0:    reg_rdata = DW'(data_q);
      4'h4:    reg_rdata = DW'(busy);
      4'h8:    reg_rdata = DW'({irq_st, ien, 1'b0, pwr, chan});
      4'hC:    reg_rdata = DW'(dly);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int RES = 10,
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctrl_we,
  input logic           wzero,
  input logic           busy,
  input logic           conv,
  input logic           irq,
  input logic           adc_pwr,
  input logic [2:0]     adc_chan,
  input logic [RES-1:0] dac_code,
  input logic [RES-1:0] data_q
);
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wzero) |=> (!busy && !irq && !adc_pwr)); // R6

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !wzero && busy) |=> $stable(adc_chan)); // R7

  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv) |-> ($onehot(dac_code) && dac_code[RES-1])); // R4

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(conv)); // R6

  AST_IRQ_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> adc_pwr); // R5

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(adc_chan) < NCH); // R8

  AST_DAC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !conv |-> dac_code == '0); // R4
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.RES(RES), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .wzero(wzero), .busy(busy),
  .conv(conv), .irq(irq), .adc_pwr(adc_pwr), .adc_chan(adc_chan),
  .dac_code(dac_code), .data_q(data_q)
);

// File: tb/tb_sar_adc_seq.sv
module tb_sar_adc_seq;
  localparam int RES = 10;
  localparam int NCH = 6;
  localparam int DW  = 32;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [3:0] reg_addr = 4'h4;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic irq, adc_pwr, cmp_hi;
  logic [2:0] adc_chan;
  logic [RES-1:0] dac_code;
  logic [RES-1:0] vin [8];
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  sar_adc_seq #(.RES(RES), .NCH(NCH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .adc_pwr(adc_pwr),
    .adc_chan(adc_chan), .dac_code(dac_code), .cmp_hi(cmp_hi)
  );

  assign cmp_hi = vin[adc_chan] >= dac_code;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = DW'(d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 4'h4;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    reg_addr = a; #1; v = int'(reg_rdata);
  endtask

  task automatic t_reset();
    int v;
    rd(4'h0, v); chk("R1 data", v, 0);
    rd(4'h4, v); chk("R1 status", v, 0);
    rd(4'h8, v); chk("R1 ctrl", v, 0);
    rd(4'hC, v); chk("R1 delay", v, 8);
    rd(4'h2, v); chk("R2 unmapped", v, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dac", int'(dac_code), 0);
  endtask

  task automatic t_convert(input int ch, input int val, input int d, input bit en);
    int v, n, ech;
    ech = (ch < NCH) ? ch : 0;
    vin[ech] = RES'(val);
    wr(4'hC, d);
    rd(4'hC, v); chk("R2 delay readback", v, d);
    wr(4'h8, (int'(en) << 5) | 8 | ch);
    n = 0; rd(4'h4, v);
    while (v[0] && n < 200) begin
      if (n == d)     chk("R3 no trial yet", int'(dac_code), 0);
      if (n == d + 1) chk("R9 R3 first trial", int'(dac_code), 1 << (RES - 1));
      if (n == d + 1) chk("R8 channel", int'(adc_chan), ech);
      n++;
      @(negedge clk); rd(4'h4, v);
    end
    chk("R3 busy length", n, d + 1 + RES);
    rd(4'h0, v); chk("R4 result", v, val);
    rd(4'h8, v); chk("R5 ctrl after done", v, 64 | (int'(en) << 5) | 8 | ch);
    chk("R5 irq", int'(irq), int'(en));
    chk("R4 dac idle", int'(dac_code), 0);
  endtask

  task automatic t_clear(input int keep);
    int v;
    wr(4'h8, 0);
    rd(4'h8, v); chk("R6 ctrl cleared", v, 0);
    chk("R6 irq low", int'(irq), 0);
    chk("R6 power off", int'(adc_pwr), 0);
    rd(4'h0, v); chk("R6 data kept", v, keep);
  endtask

  task automatic t_abort();
    int v;
    vin[2] = 10'd77;
    wr(4'hC, 20);
    wr(4'h8, 32 | 8 | 2);
    repeat (5) @(negedge clk);
    rd(4'h4, v); chk("R3 busy during delay", v, 1);
    wr(4'h8, 0);
    rd(4'h4, v); chk("R6 abort idle", v, 0);
    repeat (40) @(negedge clk);
    rd(4'h0, v); chk("R6 abort keeps data", v, 513);
    chk("R6 no irq after abort", int'(irq), 0);
  endtask

  task automatic t_busy_write();
    int v, n;
    vin[1] = 10'd300; vin[2] = 10'd900;
    wr(4'hC, 2);
    wr(4'h8, 32 | 8 | 1);
    repeat (3) @(negedge clk);
    wr(4'h8, 32 | 8 | 2);
    chk("R7 chan held", int'(adc_chan), 1);
    n = 0; rd(4'h4, v);
    while (v[0] && n < 200) begin n++; @(negedge clk); rd(4'h4, v); end
    rd(4'h0, v); chk("R7 result of first channel", v, 300);
    rd(4'h8, v); chk("R7 ctrl of first write", v, 64 | 32 | 8 | 1);
  endtask

  task automatic t_nopwr();
    int v;
    wr(4'h8, 32);
    rd(4'h8, v); chk("R10 ctrl status cleared", v, 32);
    chk("R10 irq low", int'(irq), 0);
    @(negedge clk);
    rd(4'h4, v); chk("R10 no start", v, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) vin[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_convert(0, 1023, 8, 1'b1);  t_clear(1023);
    t_convert(3, 0, 3, 1'b1);     t_clear(0);
    t_convert(5, 341, 0, 1'b0);   t_clear(341);
    t_convert(1, 682, 63, 1'b1);  t_nopwr(); t_clear(682);
    t_convert(7, 513, 1, 1'b1);   t_clear(513);
    t_abort();
    t_busy_write();
    t_clear(300);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule